// File: doc/BRIEF.md
# Vertical Laplacian Sharpening Filter

This block sharpens a raster pixel stream along the slow scan axis. Every accepted pixel is stored in a chain of two line stores. When a pixel arrives, the stores supply the pixel at the same column one line earlier and two lines earlier. The incoming pixel is the line below (B), the first store gives the centre pixel (N), and the second store gives the line above (A). From these the block computes N' = N + K*(2N - (A+B)), clamps the result to the 8-bit pixel range and presents it with a valid strobe.

The gain K is an unsigned fixed-point input with four integer and four fractional bits. The scaled difference is rounded before it is added back to N. Input pixels may arrive with idle cycles between them. The column position only moves on a valid pixel, so the line length always counts pixels and not clock cycles. The first two lines after reset only fill the line stores and produce no output. From the third line on, every input pixel yields one corrected pixel at fixed latency.

Top module: `vlap_sharpen`

## Requirements
- R1: While reset is asserted and after its release, out_valid is 0 and out_pix is 0 until the first result is produced.
- R2: No result is produced for the first 2*LINE_LEN pixels accepted after reset.
- R3: For a pixel in line L >= 2 at column c, the result is clamp(N + floor((K*(2N-A-B) + 8) / 16)). Here B is the input pixel, N is the pixel of line L-1 at column c and A is the pixel of line L-2 at column c. coef_k is read as an unsigned value in sixteenths.
- R4: The result for a pixel accepted at clock edge e is valid on out_valid/out_pix from edge e+2 on, for one cycle per accepted pixel.
- R5: Cycles with in_valid low neither advance the column or line position nor produce a result, whatever in_pix carries.
- R6: A negative sum gives out_pix = 0, and a sum above 255 gives out_pix = 255.
- R7: With coef_k = 0 the result equals N, so the block acts as a plain one-line delay.
- R8: A reset in the middle of a frame restarts the fill, and the next two lines again produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | 8 | Incoming pixel (line below) |
| coef_k | input | 8 | Sharpening gain, unsigned, 4 fractional bits |
| out_valid | output | 1 | Result strobe |
| out_pix | output | 8 | Sharpened, clamped pixel |

## Verification
The bench builds the block with LINE_LEN = 8 and the default 8-bit pixel and gain widths. At that length a whole frame of six lines is only 48 pixels, so the fill phase, line wrap and restart after reset are all reached within a few hundred cycles. With a short line, random idle gaps, random images and gains from 0 up to 15.9375 can be run across several full frames. Crafted images with extreme contrast then push the sum past both clamp limits.

// File: rtl/vlap_sharpen.sv
module vlap_sharpen #(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 1152,
  parameter int K_W      = 8,
  parameter int K_FRAC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  input  logic [K_W-1:0]   coef_k,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);
  localparam int CW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
  localparam int DW = PIX_W + 3;
  localparam int PW = DW + K_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (K_FRAC - 1);
  localparam logic signed [PW-1:0] MAXP = PW'((1 << PIX_W) - 1);

  logic [PIX_W-1:0] line_n [LINE_LEN];
  logic [PIX_W-1:0] line_a [LINE_LEN];
  logic [CW-1:0]    col;
  logic [1:0]       lines;

  wire              filled   = (lines == 2'd2);
  wire              last_col = (col == CW'(LINE_LEN - 1));
  wire [PIX_W-1:0]  cur_n    = line_n[col];
  wire [PIX_W-1:0]  cur_a    = line_a[col];

  always_ff @(posedge clk) begin
    if (in_valid) begin
      line_n[col] <= in_pix;
      line_a[col] <= cur_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col   <= '0;
      lines <= '0;
    end else if (in_valid) begin
      col <= last_col ? '0 : col + 1'b1;
      if (last_col && !filled) lines <= lines + 1'b1;
    end
  end

  logic signed [DW-1:0] diff_c;
  assign diff_c = $signed({2'b00, cur_n, 1'b0}) - $signed({3'b000, cur_a})
                - $signed({3'b000, in_pix});

  logic                 s1_v, s2_v;
  logic signed [DW-1:0] s1_d;
  logic [PIX_W-1:0]     s1_n, s2_n;
  logic signed [PW-1:0] s2_r;

  logic signed [PW-1:0] prod_c, rnd_c, sum_c;
  assign prod_c = s1_d * $signed({1'b0, coef_k});
  assign rnd_c  = (prod_c + HALF) >>> K_FRAC;
  assign sum_c  = s2_r + $signed({{(PW-PIX_W){1'b0}}, s2_n});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      out_valid <= 1'b0;
      s1_d      <= '0;
      s1_n      <= '0;
      s2_r      <= '0;
      s2_n      <= '0;
      out_pix   <= '0;
    end else begin
      s1_v      <= in_valid && filled;
      s2_v      <= s1_v;
      out_valid <= s2_v;
      if (in_valid && filled) begin
        s1_d <= diff_c;
        s1_n <= cur_n;
      end
      if (s1_v) begin
        s2_r <= rnd_c;
        s2_n <= s1_n;
      end
      if (s2_v) begin
        if (sum_c < 0)         out_pix <= '0;
        else if (sum_c > MAXP) out_pix <= '1;
        else                   out_pix <= sum_c[PIX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/vlap_sharpen_chk.sv
module vlap_sharpen_chk #(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 1152
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix
);
  localparam int FILL = 2 * LINE_LEN + 1;
  localparam int AW   = $clog2(FILL + 1) + 1;

  logic [AW-1:0] acc;
  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else if (in_valid && acc < AW'(FILL)) acc <= acc + 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid && out_pix == '0); // R1
  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> acc >= AW'(FILL)); // R2
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3)); // R4
  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid, 3) |-> !out_valid); // R5
  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({out_valid, out_pix})); // R3
endmodule

bind vlap_sharpen vlap_sharpen_chk #(.PIX_W(PIX_W), .LINE_LEN(LINE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/vlap_sharpen_bench.sv
module vlap_sharpen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LL = 8;
  localparam int NL = 6;

  logic       clk = 0, rst_n = 0, in_valid = 0;
  logic [7:0] in_pix = 0, coef_k = 0;
  logic       out_valid;
  logic [7:0] out_pix;

  vlap_sharpen #(.LINE_LEN(LL)) u_vlap_sharpen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .coef_k(coef_k), .out_valid(out_valid), .out_pix(out_pix));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int img [NL][LL];
  int q_val[$], q_cyc[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_pix(int a, int n, int b, int k);
    int p, s;
    p = (2*n - a - b) * k;
    s = n + ((p + 8) >>> 4);
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_val.size() == 0) check(0, "R2 unexpected output", out_pix, -1);
      else begin
        int v, c;
        string t;
        v = q_val.pop_front(); c = q_cyc.pop_front(); t = q_tag.pop_front();
        check(out_pix == v, t, out_pix, v);
        check(cyc == c, "R4 latency", cyc, c);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    q_val.delete(); q_cyc.delete(); q_tag.delete();
    repeat (2) @(negedge clk);
    check(out_valid == 0 && out_pix == 0, "R1 reset outputs", {out_valid, out_pix}, 0);
    rst_n = 1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      in_pix = 8'($urandom);
    end
  endtask

  task automatic send_rows(int r0, int r1, int k, bit gaps, string tag);
    for (int r = r0; r <= r1; r++)
      for (int c = 0; c < LL; c++) begin
        if (gaps && ($urandom % 3 == 0)) idle(1 + $urandom % 3);
        @(negedge clk);
        in_valid = 1; in_pix = 8'(img[r][c]);
        if (r - r0 >= 2) begin
          q_val.push_back(ref_pix(img[r-2][c], img[r-1][c], img[r][c], k));
          q_cyc.push_back(cyc + 3);
          q_tag.push_back(tag);
        end
      end
    idle(6);
    check(q_val.size() == 0, {tag, " all results produced"}, q_val.size(), 0);
  endtask

  task automatic rand_img();
    for (int r = 0; r < NL; r++)
      for (int c = 0; c < LL; c++) img[r][c] = $urandom % 256;
  endtask

  task automatic t_reset_state();
    do_reset();
    idle(3);
    check(out_valid == 0 && out_pix == 0, "R1 idle after reset", {out_valid, out_pix}, 0);
  endtask

  task automatic t_gapped_frame();
    do_reset();
    rand_img(); coef_k = 8'd16;
    send_rows(0, NL-1, 16, 1, "R5 gapped frame");
  endtask

  task automatic t_random_gains();
    int ks[5] = '{1, 8, 24, 100, 255};
    foreach (ks[i]) begin
      do_reset();
      rand_img(); coef_k = 8'(ks[i]);
      send_rows(0, NL-1, ks[i], 0, "R3 random frame");
    end
  endtask

  task automatic t_clamp();
    do_reset();
    coef_k = 8'h20;
    for (int r = 0; r < NL; r++)
      for (int c = 0; c < LL; c++) img[r][c] = ((r + c) % 2) ? 255 : 0;
    send_rows(0, NL-1, 32, 0, "R6 clamp");
  endtask

  task automatic t_k_zero();
    do_reset();
    rand_img(); coef_k = 0;
    send_rows(0, NL-1, 0, 1, "R7 zero gain");
  endtask

  task automatic t_restart();
    do_reset();
    rand_img(); coef_k = 8'd20;
    send_rows(0, 3, 20, 0, "R3 before restart");
    for (int c = 0; c < LL/2; c++) begin
      @(negedge clk); in_valid = 1; in_pix = 8'(img[4][c]);
      q_val.push_back(ref_pix(img[2][c], img[3][c], img[4][c], 20));
      q_cyc.push_back(cyc + 3); q_tag.push_back("R8 pre-reset");
    end
    idle(4);
    do_reset();
    rand_img();
    send_rows(0, NL-1, 20, 0, "R8 refill after reset");
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_gapped_frame();
        t_random_gains();
        t_clamp();
        t_k_zero();
        t_restart();
      end
      begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", cyc, 0);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule